// File: doc/BRIEF.md
# Accumulator Saturation Unit

This block takes a 64-bit signed accumulator, supplied as a high 32-bit word and a low 32-bit word, and narrows it to a 32-bit value for a destination register. An 8-bit mode code picks the range that the value is clamped to. Three of the modes clamp to a narrow signed range. In these modes a clamped result is written with its upper bits zero, and an in-range value passes through as the low 32 bits of the accumulator. The fourth mode clamps to the signed 48-bit range, then shifts arithmetically right by 16 and keeps the low 32 bits.

The caller puts the two words and the code on the inputs and raises a start strobe for one cycle. The result is registered. A one-cycle valid pulse marks it on the clock that follows the start. If the code is not one of the four supported codes, nothing is written and no pulse is given.

Top module: `acc_sat_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears result_o to 0 and valid_o to 0 at that edge.
- R2: valid_o is high in the cycle after a clock edge that samples start_i high with a supported code, and it is low in every other cycle.
- R3: Code 0x10 (16-bit): an operand greater than 32767 gives 0x00007FFF, and an operand less than -32768 gives 0x00008000.
- R4: Code 0x08 (8-bit): an operand greater than 127 gives 0x0000007F, and an operand less than -128 gives 0x00000080.
- R5: Code 0x09 (9-bit, asymmetric): an operand greater than 128 gives 0x00000080, and an operand less than -127 gives 0x00000081.
- R6: In codes 0x08, 0x09 and 0x10, an operand inside the range, limits included, gives the low 32 bits of the operand. A negative operand therefore keeps its sign-extension ones.
- R7: Code 0x30: the operand is clamped to [-2^47, 2^47-1], shifted arithmetically right by 16, and the low 32 bits are returned.
- R8: A start with any other code raises no valid pulse and leaves result_o unchanged.
- R9: The operand is {acc_hi_i, acc_lo_i}, treated as signed 64-bit, and every comparison is signed over all 64 bits. A nonzero high word decides saturation even when the low word alone is in range.
- R10: result_o holds its value in every cycle in which start_i is not sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe; operand and code are sampled with it |
| mode_i | input | 8 | Saturation mode code |
| acc_hi_i | input | 32 | Accumulator bits 63:32 |
| acc_lo_i | input | 32 | Accumulator bits 31:0 |
| result_o | output | 32 | Registered saturated result |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench drives every narrow mode exactly at each limit and one step past it. A range that is off by one would clamp or pass the wrong value there, and a design that sign-extended clamped values would return all-ones upper bits for the low clamp. It drives operands whose high word alone decides the outcome. A design that compared only the low word, or compared it unsigned, would pass 0x80000000 through or clamp it to the wrong side. The wide mode is checked at both 48-bit limits, on in-range negative values, and on a value whose shift must carry the sign in. Unsupported codes and idle cycles are checked for a stray valid pulse and for any change to the held result.

// File: rtl/accsat_pkg.sv
// Package: shared widths, mode codes, selector type and narrow-lane limits
// for the accumulator saturation unit. Assumes a 64-bit accumulator split
// into two equal words.
package accsat_pkg;
    localparam int WORD_W = 32;
    localparam int ACC_W  = 2 * WORD_W;
    localparam int MODE_W = 8;
    localparam int NARROW_LANES = 3;

    localparam logic [MODE_W-1:0] CODE_B8  = 8'h08;
    localparam logic [MODE_W-1:0] CODE_B9  = 8'h09;
    localparam logic [MODE_W-1:0] CODE_B16 = 8'h10;
    localparam logic [MODE_W-1:0] CODE_W48 = 8'h30;

    typedef enum logic [1:0] {
        SEL_B8  = 2'd0,
        SEL_B9  = 2'd1,
        SEL_B16 = 2'd2,
        SEL_W48 = 2'd3
    } sat_sel_e;

    typedef struct packed {
        logic     legal;
        sat_sel_e sel;
    } sat_dec_t;

    // Upper inclusive limit of narrow lane g.
    function automatic logic signed [ACC_W-1:0] lane_hi_lim(input int g);
        case (g)
            0:       return 64'sd127;
            1:       return 64'sd128;
            default: return 64'sd32767;
        endcase
    endfunction

    // Lower inclusive limit of narrow lane g.
    function automatic logic signed [ACC_W-1:0] lane_lo_lim(input int g);
        case (g)
            0:       return -64'sd128;
            1:       return -64'sd127;
            default: return -64'sd32768;
        endcase
    endfunction

    // Value written when lane g clamps at the top.
    function automatic logic [WORD_W-1:0] lane_hi_out(input int g);
        case (g)
            0:       return 32'h0000_007F;
            1:       return 32'h0000_0080;
            default: return 32'h0000_7FFF;
        endcase
    endfunction

    // Value written when lane g clamps at the bottom (zero-extended).
    function automatic logic [WORD_W-1:0] lane_lo_out(input int g);
        case (g)
            0:       return 32'h0000_0080;
            1:       return 32'h0000_0081;
            default: return 32'h0000_8000;
        endcase
    endfunction
endpackage

// File: rtl/accsat_decode.sv
// Module: accsat_decode
// Maps the mode code onto a lane selector and a legal flag.
// Assumes: purely combinational; any code outside the four supported ones
// is reported as not legal and its selector value is meaningless.
module accsat_decode
    import accsat_pkg::*;
#(
    parameter int CODE_W = MODE_W
) (
    input  logic [CODE_W-1:0] mode_i,
    output sat_dec_t          dec_o
);
    // Purpose: compare the code against each supported value.
    always_comb begin
        dec_o.legal = 1'b1;
        dec_o.sel   = SEL_B8;
        case (mode_i)
            CODE_B8:  dec_o.sel = SEL_B8;
            CODE_B9:  dec_o.sel = SEL_B9;
            CODE_B16: dec_o.sel = SEL_B16;
            CODE_W48: dec_o.sel = SEL_W48;
            default:  dec_o.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/accsat_narrow.sv
// Module: accsat_narrow
// Clamps a signed operand to [LO_LIM, HI_LIM]. Out-of-range values produce
// the fixed codes HI_OUT / LO_OUT; in-range values pass their low OUT_W bits.
// Assumes: limits are given as signed values of the operand width and
// LO_LIM < HI_LIM.
module accsat_narrow #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 32,
    parameter logic signed [IN_W-1:0] HI_LIM = 127,
    parameter logic signed [IN_W-1:0] LO_LIM = -128,
    parameter logic [OUT_W-1:0] HI_OUT = 'h7F,
    parameter logic [OUT_W-1:0] LO_OUT = 'h80
) (
    input  logic signed [IN_W-1:0] op_i,
    output logic [OUT_W-1:0]       res_o
);
    logic above;
    logic below;

    // Purpose: signed comparisons against both limits.
    always_comb begin
        above = (op_i > HI_LIM);
        below = (op_i < LO_LIM);
    end

    // Purpose: pick the clamp code or pass the low bits through.
    always_comb begin
        if (above)
            res_o = HI_OUT;
        else if (below)
            res_o = LO_OUT;
        else
            res_o = op_i[OUT_W-1:0];
    end
endmodule

// File: rtl/accsat_wide.sv
// Module: accsat_wide
// Clamps a signed operand to the signed KEEP_W-bit range, then shifts it
// arithmetically right by SHIFT and returns the low OUT_W bits.
// Assumes: KEEP_W - SHIFT <= OUT_W, so the shifted clamp always fits.
module accsat_wide #(
    parameter int IN_W   = 64,
    parameter int OUT_W  = 32,
    parameter int KEEP_W = 48,
    parameter int SHIFT  = 16
) (
    input  logic signed [IN_W-1:0] op_i,
    output logic [OUT_W-1:0]       res_o
);
    localparam logic signed [IN_W-1:0] W_MAX =
        {{(IN_W-KEEP_W+1){1'b0}}, {(KEEP_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] W_MIN =
        {{(IN_W-KEEP_W+1){1'b1}}, {(KEEP_W-1){1'b0}}};

    logic signed [IN_W-1:0] clamped;

    // Purpose: limit the operand to the signed KEEP_W range.
    always_comb begin
        if (op_i > W_MAX)
            clamped = W_MAX;
        else if (op_i < W_MIN)
            clamped = W_MIN;
        else
            clamped = op_i;
    end

    // Purpose: arithmetic downshift and truncation to the result width.
    always_comb begin
        res_o = OUT_W'(clamped >>> SHIFT);
    end
endmodule

// File: rtl/acc_sat_unit.sv
// Module: acc_sat_unit (top)
// Saturates a 64-bit signed accumulator to a 32-bit result under control of
// an 8-bit mode code. One start gives a registered result and a one-cycle
// valid pulse on the following clock.
// Assumes: operand and code are stable at the edge that samples start_i;
// synchronous active-low reset.
module acc_sat_unit
    import accsat_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int CODE_W = MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] mode_i,
    input  logic [DATA_W-1:0] acc_hi_i,
    input  logic [DATA_W-1:0] acc_lo_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o
);
    localparam int OP_W = 2 * DATA_W;

    logic signed [OP_W-1:0] operand;
    sat_dec_t               dec;
    logic [DATA_W-1:0]      lane_res [NARROW_LANES];
    logic [DATA_W-1:0]      wide_res;
    logic [DATA_W-1:0]      next_res;

    // Purpose: join the two words into the signed operand.
    always_comb begin
        operand = {acc_hi_i, acc_lo_i};
    end

    accsat_decode #(.CODE_W(CODE_W)) u_decode (
        .mode_i (mode_i),
        .dec_o  (dec)
    );

    // One clamp lane per narrow mode; limits come from the package.
    for (genvar g = 0; g < NARROW_LANES; g++) begin : g_lane
        accsat_narrow #(
            .IN_W   (OP_W),
            .OUT_W  (DATA_W),
            .HI_LIM (lane_hi_lim(g)),
            .LO_LIM (lane_lo_lim(g)),
            .HI_OUT (lane_hi_out(g)),
            .LO_OUT (lane_lo_out(g))
        ) u_narrow (
            .op_i  (operand),
            .res_o (lane_res[g])
        );
    end

    accsat_wide #(
        .IN_W   (OP_W),
        .OUT_W  (DATA_W),
        .KEEP_W (48),
        .SHIFT  (16)
    ) u_wide (
        .op_i  (operand),
        .res_o (wide_res)
    );

    // Purpose: choose the lane result named by the decoded selector.
    always_comb begin
        case (dec.sel)
            SEL_B8:  next_res = lane_res[0];
            SEL_B9:  next_res = lane_res[1];
            SEL_B16: next_res = lane_res[2];
            default: next_res = wide_res;
        endcase
    end

    // Purpose: capture the result and pulse valid for a legal start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= start_i && dec.legal;
            if (start_i && dec.legal)
                result_o <= next_res;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && result_o == '0)); // R1
    AST_VALID_ON_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && dec.legal) |=> valid_o); // R2
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o); // R2
    AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !dec.legal) |=> (!valid_o && $stable(result_o))); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o)); // R10
    AST_WIDE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i == CODE_W48) |=> (result_o[DATA_W-1] == $past(acc_hi_i[DATA_W-1]))); // R7
    AST_B8_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i == CODE_B8) |=> (result_o[DATA_W-1:8] == '0 || result_o[DATA_W-1:8] == '1)); // R4
endmodule

// File: tb/test_acc_sat_unit.sv
module test_acc_sat_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  mode_i = 8'h00;
    logic [31:0] acc_hi_i = '0;
    logic [31:0] acc_lo_i = '0;
    logic [31:0] result_o;
    logic        valid_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    acc_sat_unit i_acc_sat_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .mode_i   (mode_i),
        .acc_hi_i (acc_hi_i),
        .acc_lo_i (acc_lo_i),
        .result_o (result_o),
        .valid_o  (valid_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One legal start; checks result, valid pulse, and that valid drops.
    task automatic run_legal(input string req, input logic [7:0] m,
                             input logic [31:0] hi, input logic [31:0] lo,
                             input logic [31:0] exp);
        @(negedge clk);
        mode_i = m; acc_hi_i = hi; acc_lo_i = lo; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({req, " result"}, result_o, exp);
        check("R2 valid pulse", {31'd0, valid_o}, 32'd1);
        @(negedge clk);
        check("R2 valid single cycle", {31'd0, valid_o}, 32'd0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 result", result_o, 32'd0);
        check("R1 valid", {31'd0, valid_o}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic test_b16();
        run_legal("R3 above", 8'h10, 32'h0, 32'h0000_8000, 32'h0000_7FFF);
        run_legal("R3 below", 8'h10, 32'hFFFF_FFFF, 32'hFFFF_7FFF, 32'h0000_8000);
        run_legal("R6 b16 top", 8'h10, 32'h0, 32'h0000_7FFF, 32'h0000_7FFF);
        run_legal("R6 b16 bottom", 8'h10, 32'hFFFF_FFFF, 32'hFFFF_8000, 32'hFFFF_8000);
    endtask

    task automatic test_b8();
        run_legal("R4 above", 8'h08, 32'h0, 32'h0000_0080, 32'h0000_007F);
        run_legal("R4 below", 8'h08, 32'hFFFF_FFFF, 32'hFFFF_FF7F, 32'h0000_0080);
        run_legal("R6 b8 top", 8'h08, 32'h0, 32'h0000_007F, 32'h0000_007F);
        run_legal("R6 b8 bottom", 8'h08, 32'hFFFF_FFFF, 32'hFFFF_FF80, 32'hFFFF_FF80);
        run_legal("R6 b8 neg small", 8'h08, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 32'hFFFF_FFFB);
    endtask

    task automatic test_b9();
        run_legal("R5 above", 8'h09, 32'h0, 32'h0000_0081, 32'h0000_0080);
        run_legal("R5 below", 8'h09, 32'hFFFF_FFFF, 32'hFFFF_FF80, 32'h0000_0081);
        run_legal("R5 top pass", 8'h09, 32'h0, 32'h0000_0080, 32'h0000_0080);
        run_legal("R5 bottom pass", 8'h09, 32'hFFFF_FFFF, 32'hFFFF_FF81, 32'hFFFF_FF81);
    endtask

    task automatic test_signed64();
        run_legal("R9 high word positive", 8'h08, 32'h0000_0001, 32'h0000_0005, 32'h0000_007F);
        run_legal("R9 high word negative", 8'h10, 32'h8000_0000, 32'h0000_0005, 32'h0000_8000);
        run_legal("R9 low word msb", 8'h10, 32'h0, 32'h8000_0000, 32'h0000_7FFF);
    endtask

    task automatic test_w48();
        run_legal("R7 top pass", 8'h30, 32'h0000_7FFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
        run_legal("R7 above", 8'h30, 32'h0000_8000, 32'h0000_0000, 32'h7FFF_FFFF);
        run_legal("R7 far above", 8'h30, 32'h1234_5678, 32'h9ABC_DEF0, 32'h7FFF_FFFF);
        run_legal("R7 mid", 8'h30, 32'h0000_1234, 32'h5678_9ABC, 32'h1234_5678);
        run_legal("R7 bottom pass", 8'h30, 32'hFFFF_8000, 32'h0000_0000, 32'h8000_0000);
        run_legal("R7 below", 8'h30, 32'hFFFF_7FFF, 32'hFFFF_FFFF, 32'h8000_0000);
        run_legal("R7 minus one", 8'h30, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_legal("R7 sign shift", 8'h30, 32'hFFFF_FFFE, 32'h0001_0000, 32'hFFFE_0001);
    endtask

    task automatic test_illegal();
        run_legal("R3 preload", 8'h10, 32'h0, 32'h0000_1234, 32'h0000_1234);
        foreach (bad_codes[i]) begin
            @(negedge clk);
            mode_i = bad_codes[i]; acc_hi_i = 32'h7FFF_FFFF; acc_lo_i = 32'hFFFF_FFFF;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check("R8 no valid", {31'd0, valid_o}, 32'd0);
            check("R8 result held", result_o, 32'h0000_1234);
        end
    endtask

    logic [7:0] bad_codes [4] = '{8'h00, 8'h11, 8'h31, 8'hFF};

    task automatic test_idle();
        run_legal("R4 preload", 8'h08, 32'h0, 32'h0000_0042, 32'h0000_0042);
        @(negedge clk);
        mode_i = 8'h30; acc_hi_i = 32'h0000_1234; acc_lo_i = 32'h5678_9ABC;
        @(negedge clk);
        check("R10 result held", result_o, 32'h0000_0042);
        check("R10 no valid", {31'd0, valid_o}, 32'd0);
        @(negedge clk);
        check("R10 still held", result_o, 32'h0000_0042);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_b16();
        test_b8();
        test_b9();
        test_signed64();
        test_w48();
        test_illegal();
        test_idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule